// File: doc/BRIEF.md
# Integer Long-Latency Unit Interlock

This block decides when an in-order five-stage integer pipeline must slip. It watches each instruction offered for issue and any request for the result of the shared multiply/divide unit. It raises a stall whenever that instruction or request cannot proceed in the current cycle. The block does no arithmetic. It only keeps cycle counters that model how long the unit stays occupied and when its result becomes readable.

Each operation class has a fixed timing. A 32-bit multiply takes 8 cycles, a 64-bit multiply 12, a 32-bit divide 36 and a 64-bit divide 68. For the unit, the repeat interval equals the latency. Simple ALU operations, loads and stores never hold the pipe. A branch or jump occupies the issue slot for two cycles. Nothing completes out of order: a conflicting instruction waits in place, and the stall stays high until the resource is free.

The issue stage drives `issue_valid` and the class code, and advances only in cycles where `stall` is low. A stalled instruction is offered again unchanged.

Top module: `lat_interlock`

## Requirements
- R1: A synchronous reset clears every counter. In the first cycle after reset, `result_ready` is 1, `stall` is 0, and a multiply or divide is accepted at once.
- R2: Class codes 0 (ALU), 1 (load) and 2 (store), issued in any back-to-back mix, never raise `stall`.
- R3: After a branch (code 3) or jump (code 4) is accepted in cycle t, an instruction offered in cycle t+1 stalls. One offered in cycle t+2 does not stall because of the branch.
- R4: A 32-bit multiply (code 5) accepted in cycle t drives `result_ready` low in cycles t+1 to t+7 and high again in cycle t+8.
- R5: A 64-bit multiply (code 6) accepted in cycle t holds `result_ready` low for cycles t+1 to t+11 and raises it in cycle t+12.
- R6: A 32-bit divide (code 7) holds `result_ready` low for 35 cycles after acceptance and raises it in the 36th. A 64-bit divide (code 8) does so with 67 and 68.
- R7: A multiply or divide offered while the unit is occupied stalls until the repeat interval of the running operation has elapsed. It is accepted in cycle t+N, where N is the repeat of the operation accepted in cycle t.
- R8: `result_req` while `result_ready` is 0 raises `stall`. `result_req` while `result_ready` is 1 does not.
- R9: Codes 0, 1, 2, 3 and 4 issue without stall while the unit is busy, provided no result request is pending.
- R10: An instruction offered during a stall is not accepted. A branch stalled by a pending result request does not start its issue hold until the cycle in which it actually goes through.
- R11: Class codes 9 to 15 behave as ALU operations.
- R12: With no instruction offered and no result requested, `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is offered for issue this cycle |
| issue_class | input | 4 | Operation class code of the offered instruction |
| result_req | input | 1 | The instruction in decode reads the unit's result |
| stall | output | 1 | Pipeline slips this cycle |
| result_ready | output | 1 | Unit result is readable (registered) |

## Verification
The bench checks the exact cycle in which `result_ready` rises for each unit operation. An off-by-one latency load would show the rise one cycle early or late. It also re-offers a multiply or divide on every cycle of a running operation, so a repeat counter that frees the unit too soon would accept one early. A branch is stalled behind a pending result request: a design that latched the issue hold on a stalled instruction would wrongly stall the following cycle. Streams of loads and stores mixed with undefined codes confirm that only the intended classes ever hold the pipe.

// File: rtl/lat_interlock_pkg.sv
package lat_interlock_pkg;
  typedef enum logic [3:0] {
    CLS_ALU   = 4'd0,
    CLS_LOAD  = 4'd1,
    CLS_STORE = 4'd2,
    CLS_BR    = 4'd3,
    CLS_JMP   = 4'd4,
    CLS_MUL32 = 4'd5,
    CLS_MUL64 = 4'd6,
    CLS_DIV32 = 4'd7,
    CLS_DIV64 = 4'd8
  } op_class_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/lat_down_counter.sv
module lat_down_counter #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             at_one,
  output logic             is_zero
);
  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (load)
      count <= load_val;
    else if (count != '0)
      count <= count - 1'b1;
  end

  assign is_zero = (count == '0);
  assign at_one  = (count == WIDTH'(1));
endmodule

// File: rtl/lat_op_decode.sv
module lat_op_decode
  import lat_interlock_pkg::*;
#(
  parameter int MUL32_LAT = 8,
  parameter int MUL64_LAT = 12,
  parameter int DIV32_LAT = 36,
  parameter int DIV64_LAT = 68,
  parameter int MUL32_RPT = 8,
  parameter int MUL64_RPT = 12,
  parameter int DIV32_RPT = 36,
  parameter int DIV64_RPT = 68,
  parameter int BR_RPT    = 2,
  parameter int CNT_W     = 7
) (
  input  logic [3:0]       cls,
  output logic             uses_unit,
  output logic [CNT_W-1:0] lat_load,
  output logic [CNT_W-1:0] rpt_load,
  output logic [CNT_W-1:0] gap_load
);
  op_class_e op;

  always_comb begin
    op        = op_class_e'(cls);
    uses_unit = 1'b0;
    lat_load  = '0;
    rpt_load  = '0;
    gap_load  = '0;
    case (op)
      CLS_MUL32: begin
        uses_unit = 1'b1;
        lat_load  = CNT_W'(MUL32_LAT - 1);
        rpt_load  = CNT_W'(MUL32_RPT - 1);
      end
      CLS_MUL64: begin
        uses_unit = 1'b1;
        lat_load  = CNT_W'(MUL64_LAT - 1);
        rpt_load  = CNT_W'(MUL64_RPT - 1);
      end
      CLS_DIV32: begin
        uses_unit = 1'b1;
        lat_load  = CNT_W'(DIV32_LAT - 1);
        rpt_load  = CNT_W'(DIV32_RPT - 1);
      end
      CLS_DIV64: begin
        uses_unit = 1'b1;
        lat_load  = CNT_W'(DIV64_LAT - 1);
        rpt_load  = CNT_W'(DIV64_RPT - 1);
      end
      CLS_BR, CLS_JMP: begin
        gap_load  = CNT_W'(BR_RPT - 1);
      end
      default: begin
        uses_unit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lat_interlock.sv
module lat_interlock
  import lat_interlock_pkg::*;
#(
  parameter int MUL32_LAT = 8,
  parameter int MUL64_LAT = 12,
  parameter int DIV32_LAT = 36,
  parameter int DIV64_LAT = 68,
  parameter int MUL32_RPT = MUL32_LAT,
  parameter int MUL64_RPT = MUL64_LAT,
  parameter int DIV32_RPT = DIV32_LAT,
  parameter int DIV64_RPT = DIV64_LAT,
  parameter int BR_RPT    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue_valid,
  input  logic [3:0] issue_class,
  input  logic       result_req,
  output logic       stall,
  output logic       result_ready
);
  localparam int MAX_LAT = max4(MUL32_LAT, MUL64_LAT, DIV32_LAT, DIV64_LAT);
  localparam int MAX_RPT = max4(MUL32_RPT, MUL64_RPT, DIV32_RPT, DIV64_RPT);
  localparam int MAX_ALL = (MAX_LAT > MAX_RPT) ? MAX_LAT : MAX_RPT;
  localparam int CNT_W   = $clog2(((MAX_ALL > BR_RPT) ? MAX_ALL : BR_RPT) + 1);

  logic             uses_unit;
  logic [CNT_W-1:0] lat_load, rpt_load, gap_load;
  logic [CNT_W-1:0] lat_cnt, rpt_cnt, gap_cnt;
  logic             lat_one, lat_zero;
  logic             rpt_one, rpt_zero;
  logic             gap_one, gap_zero;
  logic             accept, unit_start;
  logic             ready_q;

  lat_op_decode #(
    .MUL32_LAT(MUL32_LAT), .MUL64_LAT(MUL64_LAT),
    .DIV32_LAT(DIV32_LAT), .DIV64_LAT(DIV64_LAT),
    .MUL32_RPT(MUL32_RPT), .MUL64_RPT(MUL64_RPT),
    .DIV32_RPT(DIV32_RPT), .DIV64_RPT(DIV64_RPT),
    .BR_RPT(BR_RPT), .CNT_W(CNT_W)
  ) u_dec (
    .cls      (issue_class),
    .uses_unit(uses_unit),
    .lat_load (lat_load),
    .rpt_load (rpt_load),
    .gap_load (gap_load)
  );

  // stall is combinational from registered state and this cycle's inputs
  always_comb begin
    stall = 1'b0;
    if (result_req && !ready_q)
      stall = 1'b1;
    if (issue_valid && !gap_zero)
      stall = 1'b1;
    if (issue_valid && uses_unit && !rpt_zero)
      stall = 1'b1;
  end

  assign accept     = issue_valid && !stall;
  assign unit_start = accept && uses_unit;

  lat_down_counter #(.WIDTH(CNT_W)) u_lat (
    .clk(clk), .rst(rst), .load(unit_start), .load_val(lat_load),
    .count(lat_cnt), .at_one(lat_one), .is_zero(lat_zero)
  );

  lat_down_counter #(.WIDTH(CNT_W)) u_rpt (
    .clk(clk), .rst(rst), .load(unit_start), .load_val(rpt_load),
    .count(rpt_cnt), .at_one(rpt_one), .is_zero(rpt_zero)
  );

  lat_down_counter #(.WIDTH(CNT_W)) u_gap (
    .clk(clk), .rst(rst), .load(accept), .load_val(gap_load),
    .count(gap_cnt), .at_one(gap_one), .is_zero(gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst)
      ready_q <= 1'b1;
    else if (unit_start)
      ready_q <= (lat_load == '0);
    else if (lat_one)
      ready_q <= 1'b1;
  end

  assign result_ready = ready_q;
endmodule

// File: rtl/lat_interlock_chk.sv
module lat_interlock_chk #(
  parameter int MUL32_LAT = 8,
  parameter int MUL64_LAT = 12,
  parameter int DIV32_LAT = 36,
  parameter int DIV64_LAT = 68,
  parameter int MUL32_RPT = 8,
  parameter int MUL64_RPT = 12,
  parameter int DIV32_RPT = 36,
  parameter int DIV64_RPT = 68
) (
  input logic       clk,
  input logic       rst,
  input logic       issue_valid,
  input logic [3:0] issue_class,
  input logic       result_req,
  input logic       stall,
  input logic       result_ready
);
  logic is_unit, is_mem, is_br, took;
  int   exp_lat, exp_rpt, want_lat, want_rpt;

  always_comb begin
    is_unit  = (issue_class >= 4'd5) && (issue_class <= 4'd8);
    is_mem   = (issue_class == 4'd1) || (issue_class == 4'd2);
    is_br    = (issue_class == 4'd3) || (issue_class == 4'd4);
    took     = issue_valid && !stall;
    want_lat = (issue_class == 4'd5) ? MUL32_LAT :
               (issue_class == 4'd6) ? MUL64_LAT :
               (issue_class == 4'd7) ? DIV32_LAT : DIV64_LAT;
    want_rpt = (issue_class == 4'd5) ? MUL32_RPT :
               (issue_class == 4'd6) ? MUL64_RPT :
               (issue_class == 4'd7) ? DIV32_RPT : DIV64_RPT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_lat <= 0;
      exp_rpt <= 0;
    end else if (took && is_unit) begin
      exp_lat <= want_lat - 1;
      exp_rpt <= want_rpt - 1;
    end else begin
      if (exp_lat > 0) exp_lat <= exp_lat - 1;
      if (exp_rpt > 0) exp_rpt <= exp_rpt - 1;
    end
  end

  // R1
  reset_ready_chk: assert property (@(posedge clk) $past(rst) |-> result_ready);

  // R8
  result_wait_chk: assert property (@(posedge clk) disable iff (rst)
    result_req && !result_ready |-> stall);

  // R2
  mem_stream_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid && is_mem && !result_req && $past(issue_valid && is_mem && !stall) |-> !stall);

  // R3
  branch_gap_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid && $past(issue_valid && is_br && !stall && !rst) |-> stall);

  // R4
  ready_timing_chk: assert property (@(posedge clk) disable iff (rst)
    result_ready == (exp_lat == 0));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid && is_unit && (exp_rpt != 0) |-> stall);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !issue_valid && !result_req |-> !stall);
endmodule

bind lat_interlock lat_interlock_chk #(
  .MUL32_LAT(MUL32_LAT), .MUL64_LAT(MUL64_LAT),
  .DIV32_LAT(DIV32_LAT), .DIV64_LAT(DIV64_LAT),
  .MUL32_RPT(MUL32_RPT), .MUL64_RPT(MUL64_RPT),
  .DIV32_RPT(DIV32_RPT), .DIV64_RPT(DIV64_RPT)
) u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_class(issue_class),
  .result_req(result_req), .stall(stall), .result_ready(result_ready)
);

// File: tb/lat_interlock_test.sv
module lat_interlock_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [3:0] issue_class = 4'd0;
  logic       result_req = 1'b0;
  logic       stall, result_ready;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [1:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  lat_interlock uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_class(issue_class),
    .result_req(result_req), .stall(stall), .result_ready(result_ready)
  );

  // monitor: compare mid-cycle
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_checks++;
      if ({stall, result_ready} !== e) begin
        n_fail++;
        $display("FAIL %s: stall=%0b ready=%0b expected stall=%0b ready=%0b",
                 t, stall, result_ready, e[1], e[0]);
      end
    end
  end

  task automatic cyc(input bit v, input logic [3:0] c, input bit req,
                     input bit es, input bit er, input string tag);
    issue_valid = v;
    issue_class = c;
    result_req  = req;
    q_exp.push_back({es, er});
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    issue_valid = 1'b0;
    result_req  = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  // unit op accepted now; retry same class every cycle until freed at n
  task automatic unit_retry(input logic [3:0] c, input int n, input string tag);
    cyc(1, c, 0, 0, 1, tag);
    for (int k = 1; k < n; k++) cyc(1, c, 0, 1, 0, tag);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: stall=%0b ready=%0b expected run to complete", stall, result_ready);
      finish_up();
    end
  end

  initial begin
    do_reset();
    // R1 reset state, R12 quiet
    cyc(0, 4'd0, 0, 0, 1, "R1");
    cyc(0, 4'd0, 0, 0, 1, "R12");
    // R8 request when ready
    cyc(0, 4'd0, 1, 0, 1, "R8");
    // R2 memory/ALU mix, R11 undefined codes
    cyc(1, 4'd1, 0, 0, 1, "R2");
    cyc(1, 4'd2, 0, 0, 1, "R2");
    cyc(1, 4'd1, 0, 0, 1, "R2");
    cyc(1, 4'd1, 0, 0, 1, "R2");
    cyc(1, 4'd2, 0, 0, 1, "R2");
    cyc(1, 4'd0, 0, 0, 1, "R2");
    cyc(1, 4'd9, 0, 0, 1, "R11");
    cyc(1, 4'd15, 0, 0, 1, "R11");
    cyc(1, 4'd12, 0, 0, 1, "R11");
    // R3 branch then ALU
    cyc(1, 4'd3, 0, 0, 1, "R3");
    cyc(1, 4'd0, 0, 1, 1, "R3");
    cyc(1, 4'd0, 0, 0, 1, "R3");
    // R3 jump, idle slot, then free
    cyc(1, 4'd4, 0, 0, 1, "R3");
    cyc(0, 4'd0, 0, 0, 1, "R3");
    cyc(1, 4'd0, 0, 0, 1, "R3");
    // R3 branch after branch
    cyc(1, 4'd3, 0, 0, 1, "R3");
    cyc(1, 4'd3, 0, 1, 1, "R3");
    cyc(1, 4'd3, 0, 0, 1, "R3");
    cyc(1, 4'd0, 0, 1, 1, "R3");
    cyc(1, 4'd0, 0, 0, 1, "R3");
    // R4 and R7: mul32 repeat/latency 8
    unit_retry(4'd5, 8, "R4");
    // second mul32 accepted now (ready at this cycle)
    cyc(1, 4'd5, 0, 0, 1, "R7");
    for (int k = 1; k <= 6; k++) cyc(1, 4'd1, 0, 0, 0, "R9");
    cyc(0, 4'd0, 1, 1, 0, "R8");
    cyc(0, 4'd0, 1, 0, 1, "R8");
    // R5 mul64, retried with div32
    cyc(1, 4'd6, 0, 0, 1, "R5");
    for (int k = 1; k < 12; k++) cyc(1, 4'd7, 0, 1, 0, "R5");
    cyc(1, 4'd7, 0, 0, 1, "R5");
    // R6 div32 result requested every cycle
    for (int k = 1; k < 36; k++) cyc(0, 4'd0, 1, 1, 0, "R6");
    cyc(0, 4'd0, 1, 0, 1, "R6");
    // R6 div64, R9 branch while busy, R10 branch held by result wait
    cyc(1, 4'd8, 0, 0, 1, "R6");
    cyc(1, 4'd3, 0, 0, 0, "R9");
    cyc(1, 4'd0, 0, 1, 0, "R9");
    for (int k = 3; k < 67; k++) cyc(0, 4'd0, 0, 0, 0, "R6");
    cyc(1, 4'd3, 1, 1, 0, "R10");
    cyc(1, 4'd3, 1, 0, 1, "R10");
    cyc(1, 4'd0, 0, 1, 1, "R10");
    cyc(1, 4'd0, 0, 0, 1, "R10");
    // R7 with mul64 retry cadence
    unit_retry(4'd6, 12, "R7");
    cyc(1, 4'd8, 0, 0, 1, "R7");
    cyc(1, 4'd5, 0, 1, 0, "R7");
    // R1 reset mid-operation
    do_reset();
    cyc(1, 4'd5, 1, 0, 1, "R1");
    cyc(0, 4'd0, 0, 0, 0, "R1");
    cyc(0, 4'd0, 1, 1, 0, "R8");
    done = 1'b1;
    finish_up();
  end
endmodule